// File: doc/BRIEF.md
# Pin-Change and External Interrupt Front End

This block collects interrupt events for a small microcontroller core. It watches one dedicated external interrupt pin and twelve general I/O pins, which form two change-detect groups: a low group of eight pins and a high group of four. Every pin goes through a two-flop synchronizer. A change on a pin is counted only when that pin's bit is set in its group's mask register. All pins of a group share one flag. The external pin has its own flag, and a two-bit sense field picks what sets it: any change, a falling edge, a rising edge, or a low level.

The core sees one request line and a two-bit vector index. When the core services a source it pulses an acknowledge, and that clears the flag of the granted source. Software reaches the control, flag and mask registers through a byte-wide register port, and can clear a flag by writing a one to it.

Top module: `pinirq_top`

## Requirements
- R1: After reset, all four registers read 0x00, and `irq_req` and `irq_vec` are 0.
- R2: The register addresses are 0 control, 1 flags and 2 group-0 mask, and 3 group-1 mask. In the flag register, bit 6 is the external flag, bit 5 is the group-1 flag and bit 4 is the group-0 flag. Bits 7 and 3..0 of the flag register always read zero.
- R3: A level change on any of pins 7..0 whose mask bit is set in the group-0 mask sets flag bit 4. The flag is readable after the third rising clock edge following the pin change, and not after the second. A change on a masked-off pin leaves the flag at zero.
- R4: A level change on pins 11..8 sets flag bit 5 when the matching bit (3..0) of the group-1 mask is set. Bits 7..4 of the group-1 mask always read zero.
- R5: The control register holds the sense mode in bits 1..0, the group-0 enable in bit 4, the group-1 enable in bit 5 and the external enable in bit 6. Its other bits read zero. `irq_req` is high only while `gie` is high and at least one enabled source is pending.
- R6: Sense mode 01 sets the external flag on any change, mode 10 on a falling edge only, and mode 11 on a rising edge only.
- R7: In sense mode 00 the external flag is held at zero. The external source is pending for as long as the synchronized pin is low.
- R8: Writing a one to a flag bit clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R9: A one-cycle pulse on `irq_ack` clears only the flag of the source that `irq_vec` shows in that cycle.
- R10: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R11: Among pending, enabled sources, the external pin wins over group 0, and group 0 wins over group 1. `irq_vec` is 1 for the external pin, 2 for group 0, 3 for group 1, and 0 when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| gpio_pin | input | 12 | I/O pins; 7..0 form group 0, 11..8 form group 1 |
| gie | input | 1 | Global interrupt enable from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Index of the granted source |
| irq_ack | input | 1 | Acknowledge pulse for the granted source |

## Verification
Several patterns are applied to group 0:
- A toggle on a masked-off pin against a toggle on a masked-on pin, which separates mask gating from plain change detection.
- Rising and falling toggles of the same pin, which confirm that both directions count.
- A sample taken one edge early against one taken on time, which pins down the synchronizer latency.

Each external sense mode is driven with both a rising and a falling edge, so that edge selectivity is told apart from any-change behaviour. Level mode is checked through the request line alone. The priority test raises all three sources in the same cycle and then acknowledges them one at a time, which shows both the grant order and that each acknowledge clears only its own flag.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_t;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_FLAG = 2'd1;
   localparam logic [1:0] ADDR_MSK0 = 2'd2;
   localparam logic [1:0] ADDR_MSK1 = 2'd3;

   localparam int unsigned BIT_EXT = 6;
   localparam int unsigned BIT_G1  = 5;
   localparam int unsigned BIT_G0  = 4;

   localparam int unsigned N_SRC = 3;   // priority order: ext, group0, group1
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
   parameter int unsigned W      = 13,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pinirq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         q_prev <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         q_prev <= stg[STAGES-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pinirq_extsense.sv
module pinirq_extsense
   import pinirq_pkg::*;
(
   input  sense_t mode,
   input  logic   now,
   input  logic   prev,
   output logic   hit,
   output logic   level
);
   always_comb begin
      hit   = 1'b0;
      level = 1'b0;
      unique case (mode)
         SENSE_LOW:  level = 1'b1;
         SENSE_ANY:  hit   = now ^ prev;
         SENSE_FALL: hit   = prev & ~now;
         SENSE_RISE: hit   = now & ~prev;
         default:    hit   = 1'b0;
      endcase
   end
endmodule

// File: rtl/pinirq_prio.sv
module pinirq_prio #(
   parameter int unsigned N  = 3,
   parameter int unsigned IW = $clog2(N + 1)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      idx   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            grant[i] = 1'b1;
            idx      = IW'(i + 1);
            found    = 1'b1;
         end
      end
   end

   assign any = |req;
endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
   import pinirq_pkg::*;
#(
   parameter int unsigned N_GRP0      = 8,
   parameter int unsigned N_GRP1      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ext_pin,
   input  logic [N_GRP0+N_GRP1-1:0] gpio_pin,
   input  logic                     gie,
   input  logic                     reg_wr,
   input  logic [1:0]               reg_addr,
   input  logic [7:0]               reg_wdata,
   output logic [7:0]               reg_rdata,
   output logic                     irq_req,
   output logic [1:0]               irq_vec,
   input  logic                     irq_ack
);
   localparam int unsigned N_PIN = N_GRP0 + N_GRP1;
   localparam int unsigned SYN_W = N_PIN + 1;

   generate
      if (N_GRP0 < 1 || N_GRP0 > 8) begin : g_bad_g0
         $error("pinirq_top: N_GRP0 must be 1..8");
      end
      if (N_GRP1 < 1 || N_GRP1 > 8) begin : g_bad_g1
         $error("pinirq_top: N_GRP1 must be 1..8");
      end
   endgenerate

   // synchronizers: bit 0 is the external pin, bits N_PIN..1 the I/O pins
   logic [SYN_W-1:0] syn_q, syn_prev;

   pinirq_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({gpio_pin, ext_pin}),
      .q      (syn_q),
      .q_prev (syn_prev)
   );

   logic              ext_now, ext_old;
   logic [N_PIN-1:0]  pin_chg;
   assign ext_now = syn_q[0];
   assign ext_old = syn_prev[0];
   assign pin_chg = syn_q[SYN_W-1:1] ^ syn_prev[SYN_W-1:1];

   // registers
   sense_t            sense_q;
   logic              en_ext_q, en_g0_q, en_g1_q;
   logic [N_GRP0-1:0] mask0_q;
   logic [N_GRP1-1:0] mask1_q;
   logic              f_ext, f_g0, f_g1;

   // event detection
   logic set_ext, set_g0, set_g1, level_mode;

   pinirq_extsense u_ext (
      .mode  (sense_q),
      .now   (ext_now),
      .prev  (ext_old),
      .hit   (set_ext),
      .level (level_mode)
   );

   assign set_g0 = |(pin_chg[N_GRP0-1:0]     & mask0_q);
   assign set_g1 = |(pin_chg[N_PIN-1:N_GRP0] & mask1_q);

   // arbitration
   logic [N_SRC-1:0] pend, grant;
   logic             any_req;
   logic [1:0]       vec;

   assign pend[0] = gie & en_ext_q & (level_mode ? ~ext_now : f_ext);
   assign pend[1] = gie & en_g0_q  & f_g0;
   assign pend[2] = gie & en_g1_q  & f_g1;

   pinirq_prio #(.N(N_SRC), .IW(2)) u_prio (
      .req   (pend),
      .grant (grant),
      .idx   (vec),
      .any   (any_req)
   );

   assign irq_req = any_req;
   assign irq_vec = vec;

   // clear sources
   logic wr_flag, clr_ext, clr_g0, clr_g1;
   assign wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
   assign clr_ext = (wr_flag & reg_wdata[BIT_EXT]) | (irq_ack & grant[0]);
   assign clr_g0  = (wr_flag & reg_wdata[BIT_G0])  | (irq_ack & grant[1]);
   assign clr_g1  = (wr_flag & reg_wdata[BIT_G1])  | (irq_ack & grant[2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_ext <= 1'b0;
         f_g0  <= 1'b0;
         f_g1  <= 1'b0;
      end else begin
         f_ext <= level_mode ? 1'b0 : (set_ext | (f_ext & ~clr_ext));
         f_g0  <= set_g0 | (f_g0 & ~clr_g0);
         f_g1  <= set_g1 | (f_g1 & ~clr_g1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q  <= SENSE_LOW;
         en_ext_q <= 1'b0;
         en_g0_q  <= 1'b0;
         en_g1_q  <= 1'b0;
         mask0_q  <= '0;
         mask1_q  <= '0;
      end else if (reg_wr) begin
         unique case (reg_addr)
            ADDR_CTRL: begin
               sense_q  <= sense_t'(reg_wdata[1:0]);
               en_g0_q  <= reg_wdata[BIT_G0];
               en_g1_q  <= reg_wdata[BIT_G1];
               en_ext_q <= reg_wdata[BIT_EXT];
            end
            ADDR_MSK0: mask0_q <= reg_wdata[N_GRP0-1:0];
            ADDR_MSK1: mask1_q <= reg_wdata[N_GRP1-1:0];
            default: ;
         endcase
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[1:0]     = sense_q;
            reg_rdata[BIT_G0]  = en_g0_q;
            reg_rdata[BIT_G1]  = en_g1_q;
            reg_rdata[BIT_EXT] = en_ext_q;
         end
         ADDR_FLAG: begin
            reg_rdata[BIT_G0]  = f_g0;
            reg_rdata[BIT_G1]  = f_g1;
            reg_rdata[BIT_EXT] = f_ext;
         end
         ADDR_MSK0: reg_rdata = 8'(mask0_q);
         ADDR_MSK1: reg_rdata = 8'(mask1_q);
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gie,
   input logic       irq_req,
   input logic [1:0] irq_vec,
   input logic       irq_ack,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_rdata,
   input logic [1:0] mode,
   input logic       f_ext,
   input logic       f_g0,
   input logic       f_g1,
   input logic       set_g0,
   input logic       set_g1
);
   a_r5_no_req_without_gie: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_req);

   a_r11_idle_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == 2'd0));

   a_r2_reserved_flag_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd1) |-> (reg_rdata[7] == 1'b0 && reg_rdata[3:0] == 4'd0));

   a_r7_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> !f_ext);

   a_r10_set_wins_g0: assert property (@(posedge clk) disable iff (!rst_n)
      set_g0 |=> f_g0);

   a_r10_set_wins_g1: assert property (@(posedge clk) disable iff (!rst_n)
      set_g1 |=> f_g1);

   a_r9_ack_clears_g1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_vec == 2'd3 && !set_g1) |=> !f_g1);
endmodule

bind pinirq_top pinirq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gie       (gie),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .irq_ack   (irq_ack),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .mode      (sense_q),
   .f_ext     (f_ext),
   .f_g0      (f_g0),
   .f_g1      (f_g1),
   .set_g0    (set_g0),
   .set_g1    (set_g1)
);

// File: tb/tb_pinirq_top.sv
`timescale 1ns/1ps
module tb_pinirq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_pin = 1'b0;
   logic [11:0] gpio_pin = '0;
   logic        gie = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_req;
   logic [1:0]  irq_vec;
   logic        irq_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pinirq_top dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gpio_pin(gpio_pin),
      .gie(gie), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
   );

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step(1);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic req_chk(input logic r, input logic [1:0] v, input string req);
      #1;
      check(irq_req == r && irq_vec == v, req, {irq_req, irq_vec}, {r, v});
   endtask

   task automatic ack_pulse();
      irq_ack = 1'b1;
      step(1);
      irq_ack = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk(2'd0, 8'h00, "R1 ctrl");
      rd_chk(2'd1, 8'h00, "R1 flags");
      rd_chk(2'd2, 8'h00, "R1 mask0");
      rd_chk(2'd3, 8'h00, "R1 mask1");
      req_chk(1'b0, 2'd0, "R1 request");
   endtask

   task automatic t_layout();
      wr(2'd1, 8'hFF);
      rd_chk(2'd1, 8'h00, "R2 flag reserved bits");
      wr(2'd3, 8'hFF);
      rd_chk(2'd3, 8'h0F, "R4 mask1 upper bits");
      wr(2'd2, 8'hA5);
      rd_chk(2'd2, 8'hA5, "R2 mask0 readback");
      wr(2'd0, 8'hFF);
      rd_chk(2'd0, 8'h73, "R5 ctrl layout");
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_grp0();
      wr(2'd2, 8'h04);
      gpio_pin[5] = ~gpio_pin[5];
      step(3);
      rd_chk(2'd1, 8'h00, "R3 masked pin ignored");
      gpio_pin[2] = ~gpio_pin[2];
      step(2);
      rd_chk(2'd1, 8'h00, "R3 not yet after two edges");
      step(1);
      rd_chk(2'd1, 8'h10, "R3 set after three edges");
      wr(2'd1, 8'h10);
      gpio_pin[2] = ~gpio_pin[2];
      step(3);
      rd_chk(2'd1, 8'h10, "R3 opposite direction change");
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_grp1();
      wr(2'd3, 8'h02);
      gpio_pin[8] = ~gpio_pin[8];
      step(3);
      rd_chk(2'd1, 8'h00, "R4 masked pin 8 ignored");
      gpio_pin[9] = ~gpio_pin[9];
      step(3);
      rd_chk(2'd1, 8'h20, "R4 pin 9 sets group1 flag");
      wr(2'd1, 8'h20);
      wr(2'd3, 8'h00);
   endtask

   task automatic t_modes();
      wr(2'd0, 8'h03);   // rising
      ext_pin = 1'b1; step(3);
      rd_chk(2'd1, 8'h40, "R6 rising sets");
      wr(2'd1, 8'h40);
      ext_pin = 1'b0; step(3);
      rd_chk(2'd1, 8'h00, "R6 rising ignores fall");
      wr(2'd0, 8'h02);   // falling
      ext_pin = 1'b1; step(3);
      rd_chk(2'd1, 8'h00, "R6 falling ignores rise");
      ext_pin = 1'b0; step(3);
      rd_chk(2'd1, 8'h40, "R6 falling sets");
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h01);   // any change
      ext_pin = 1'b1; step(3);
      rd_chk(2'd1, 8'h40, "R6 any change on rise");
      wr(2'd1, 8'h40);
      ext_pin = 1'b0; step(3);
      rd_chk(2'd1, 8'h40, "R6 any change on fall");
      wr(2'd1, 8'h40);
   endtask

   task automatic t_level();
      gie = 1'b1;
      wr(2'd0, 8'h40);   // level mode, ext enabled; pin low
      req_chk(1'b1, 2'd1, "R7 low level requests");
      rd_chk(2'd1, 8'h00, "R7 flag held zero");
      ext_pin = 1'b1; step(2);
      req_chk(1'b0, 2'd0, "R7 high level no request");
      rd_chk(2'd1, 8'h00, "R7 flag zero after edge");
      ext_pin = 1'b0; step(2);
      req_chk(1'b1, 2'd1, "R7 low again requests");
      wr(2'd0, 8'h01);
      gie = 1'b0;
      wr(2'd1, 8'h70);
   endtask

   task automatic t_w1c();
      wr(2'd2, 8'h01);
      gpio_pin[0] = ~gpio_pin[0]; step(3);
      rd_chk(2'd1, 8'h10, "R8 flag set");
      wr(2'd1, 8'h00);
      rd_chk(2'd1, 8'h10, "R8 write zero keeps");
      wr(2'd1, 8'hEF);
      rd_chk(2'd1, 8'h10, "R8 other ones keep");
      wr(2'd1, 8'h10);
      rd_chk(2'd1, 8'h00, "R8 write one clears");
   endtask

   task automatic t_gie();
      gpio_pin[0] = ~gpio_pin[0]; step(3);
      wr(2'd0, 8'h11);
      gie = 1'b0; req_chk(1'b0, 2'd0, "R5 gie low blocks");
      gie = 1'b1; req_chk(1'b1, 2'd2, "R5 gie high requests");
      wr(2'd0, 8'h01);
      req_chk(1'b0, 2'd0, "R5 enable off blocks");
      wr(2'd1, 8'h10);
   endtask

   task automatic t_setwins();
      wr(2'd0, 8'h01);
      gpio_pin[0] = ~gpio_pin[0];
      step(2);
      wr(2'd1, 8'h10);   // clear lands on the set cycle
      rd_chk(2'd1, 8'h10, "R10 set beats write-one");
      wr(2'd1, 8'h10);
      rd_chk(2'd1, 8'h00, "R10 cleared afterwards");
   endtask

   task automatic t_prio();
      gie = 1'b1;
      wr(2'd0, 8'h73);   // rising, all enabled
      wr(2'd2, 8'h01);
      wr(2'd3, 8'h01);
      ext_pin = 1'b1;
      gpio_pin[0] = ~gpio_pin[0];
      gpio_pin[8] = ~gpio_pin[8];
      step(3);
      rd_chk(2'd1, 8'h70, "R11 all pending");
      req_chk(1'b1, 2'd1, "R11 external first");
      ack_pulse();
      rd_chk(2'd1, 8'h30, "R9 ack clears external only");
      req_chk(1'b1, 2'd2, "R11 group0 second");
      ack_pulse();
      rd_chk(2'd1, 8'h20, "R9 ack clears group0 only");
      req_chk(1'b1, 2'd3, "R11 group1 last");
      ack_pulse();
      rd_chk(2'd1, 8'h00, "R9 ack clears group1");
      req_chk(1'b0, 2'd0, "R11 idle vector");
      gie = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_layout();
      t_grp0();
      t_grp1();
      t_modes();
      t_level();
      t_w1c();
      t_gie();
      t_setwins();
      t_prio();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule